// File: doc/BRIEF.md
# Multiplexed-Bus Whole-Port I/O Expander

This block sits between a microcontroller that shares one 8-bit bus for address and data and a group of 8-bit general-purpose ports. The host first puts a register address on the bus and pulses the address strobe. The block keeps that address in an internal latch. The host then writes or reads that register with the write and read strobes while chip select is low. All host strobes are asynchronous to the block. They pass through a synchronizer onto a system clock, and the falling edge of the address strobe and the rising edge of the write strobe are turned into single-cycle pulses.

Each whole-port channel has one direction bit that covers all eight pins. In output mode the pins drive a latched data register. In input mode the pins float, and a read returns the live pin levels. The direction bits and three spare control bits sit in one shared control register. Every register can be read back. The lowest addresses belong to a neighbouring per-bit port and interrupt block. This block passes writes to those addresses out as a one-cycle pulse with address and data, and it returns the neighbour's read data for them. Pads are modelled as separate out, output-enable and in vectors.

Top module: `mbus_port_expander`

## Requirements
- R1: The register address is the bus value captured when the synchronized address strobe falls. Later bus activity does not move it until the next falling edge. The host holds the address for at least 4 clocks after the strobe falls.
- R2: While chip select (active low) is high, write strobes change no register and the bus is never driven.
- R3: While chip select and read strobe are both low (after 2 synchronizer clocks), `ad_oe_o` is 1 and `ad_o` carries the addressed register. It returns to 0 once the read strobe rises.
- R4: A write takes effect on the clock after the synchronized write strobe rises. The bus value at that moment is stored, so data is held at least 4 clocks after the strobe rises.
- R5: Channel k (data address PORT_BASE+k, default B=0x03, C=0x04) drives all 8 pins from its data register when control bit k is 1. When that bit is 0, all 8 output enables are 0.
- R6: A read of a channel's data address returns its data register in output mode and the live pin value in input mode.
- R7: The control register at PORT_BASE+NPORTS (default 0x05) reads back all 8 written bits. Bits 7:5 appear on `ctrl_o[2:0]`.
- R8: Addresses below PORT_BASE (0x00–0x02) are external. A write gives exactly one `ext_wr_o` pulse with `ext_addr_o`/`ext_wdata_o` and changes no local register. A read returns `ext_rdata_i`.
- R9: While `rst_n` is low, every register clears, so all channels are inputs, all output enables are 0, `ctrl_o` is 0 and the bus is not driven.
- R10: An address above the control register reads as 0x00, and a write to it changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ale_i | input | 1 | Address strobe; address captured on its fall |
| cs_n_i | input | 1 | Chip select, active low |
| rd_n_i | input | 1 | Read strobe, active low |
| wr_n_i | input | 1 | Write strobe, active low |
| ad_i | input | 8 | Shared address/data bus, inbound |
| ad_o | output | 8 | Read data toward the host |
| ad_oe_o | output | 1 | Bus drive enable |
| port_out_o | output | 8*NPORTS | Channel pad output values |
| port_oe_o | output | 8*NPORTS | Channel pad output enables |
| port_in_i | input | 8*NPORTS | Channel pad input values |
| ctrl_o | output | 3 | Control bits 7:5 for the neighbouring block |
| ext_wr_o | output | 1 | Write pulse for an external register |
| ext_addr_o | output | 8 | Latched address for external access |
| ext_wdata_o | output | 8 | Write data for external access |
| ext_rdata_i | input | 8 | External register read data |

## Verification
Writes and reads are tried in several patterns. A port is written while it is an input and then turned to an output, which shows that the data register and the output enable are separate. Pin values are set apart from the register contents, so a read shows whether the mux picked the register or the pins. A bus cycle with chip select high, and a cycle where the bus changes to another address after the strobe falls, show the gating and the address latch. External, unmapped and control addresses are each written and read back, so a decode fault that moves a write to the wrong register can be seen.

// File: rtl/mpx_pkg.sv
package mpx_pkg;
   localparam int unsigned BUS_W   = 8;
   localparam int unsigned NSTROBE = 4;
   // strobe vector slots
   localparam int unsigned S_ALE = 0;
   localparam int unsigned S_CS  = 1;
   localparam int unsigned S_RD  = 2;
   localparam int unsigned S_WR  = 3;
   typedef logic [BUS_W-1:0] byte_t;
endpackage

// File: rtl/mpx_sync.sv
module mpx_sync #(
   parameter int unsigned WIDTH  = 4,
   parameter int unsigned STAGES = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("mpx_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q[s] <= RST_VAL;
         else if (s == 0) chain_q[s] <= d_i;
         else chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
      end
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/mpx_bus_ctrl.sv
module mpx_bus_ctrl
   import mpx_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  ale_i,
   input  logic  cs_n_i,
   input  logic  rd_n_i,
   input  logic  wr_n_i,
   input  byte_t ad_i,
   output byte_t addr_o,
   output logic  we_o,
   output byte_t wdata_o,
   output logic  rd_en_o
);
   localparam logic [NSTROBE-1:0] IDLE_LVL = 4'b1110; // ALE low, others high

   logic [NSTROBE-1:0] raw, syn, syn_d;
   byte_t addr_q;
   logic ale_fall, wr_rise;

   assign raw[S_ALE] = ale_i;
   assign raw[S_CS]  = cs_n_i;
   assign raw[S_RD]  = rd_n_i;
   assign raw[S_WR]  = wr_n_i;

   mpx_sync #(.WIDTH(NSTROBE), .STAGES(SYNC_STAGES), .RST_VAL(IDLE_LVL)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i(raw), .q_o(syn)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) syn_d <= IDLE_LVL;
      else syn_d <= syn;
   end

   assign ale_fall = syn_d[S_ALE] & ~syn[S_ALE];
   assign wr_rise  = ~syn_d[S_WR] & syn[S_WR];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) addr_q <= '0;
      else if (ale_fall) addr_q <= ad_i;
   end

   assign addr_o  = addr_q;
   assign we_o    = wr_rise & ~syn[S_CS];
   assign wdata_o = ad_i;
   assign rd_en_o = ~syn[S_CS] & ~syn[S_RD];

   AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !ale_fall |=> $stable(addr_o)) else $error("address moved without strobe"); // R1
endmodule

// File: rtl/mpx_whole_port.sv
module mpx_whole_port
   import mpx_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  we_i,
   input  byte_t wdata_i,
   input  logic  dir_out_i,
   input  byte_t pin_in_i,
   output byte_t pin_out_o,
   output byte_t pin_oe_o,
   output byte_t rdata_o
);
   byte_t data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) data_q <= '0;
      else if (we_i) data_q <= wdata_i;
   end

   assign pin_out_o = data_q;
   assign pin_oe_o  = {BUS_W{dir_out_i}};
   assign rdata_o   = dir_out_i ? data_q : pin_in_i;

   AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !we_i |=> $stable(pin_out_o)) else $error("port data changed without write"); // R4
endmodule

// File: rtl/mbus_port_expander.sv
module mbus_port_expander
   import mpx_pkg::*;
#(
   parameter int unsigned NPORTS      = 2,
   parameter int unsigned PORT_BASE   = 3,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  ale_i,
   input  logic                  cs_n_i,
   input  logic                  rd_n_i,
   input  logic                  wr_n_i,
   input  logic [7:0]            ad_i,
   output logic [7:0]            ad_o,
   output logic                  ad_oe_o,
   output logic [8*NPORTS-1:0]   port_out_o,
   output logic [8*NPORTS-1:0]   port_oe_o,
   input  logic [8*NPORTS-1:0]   port_in_i,
   output logic [2:0]            ctrl_o,
   output logic                  ext_wr_o,
   output logic [7:0]            ext_addr_o,
   output logic [7:0]            ext_wdata_o,
   input  logic [7:0]            ext_rdata_i
);
   localparam int unsigned CTRL_IDX = PORT_BASE + NPORTS;
   localparam byte_t CTRL_ADDR = byte_t'(CTRL_IDX);
   localparam byte_t BASE_ADDR = byte_t'(PORT_BASE);

   if (NPORTS < 1 || NPORTS > 5) begin : g_bad_nports
      $error("mbus_port_expander: NPORTS must be 1..5 (direction bits share the control byte)");
   end
   if (CTRL_IDX > 255) begin : g_bad_base
      $error("mbus_port_expander: register map exceeds 8-bit address space");
   end

   byte_t addr, wdata;
   logic  we, rd_en;
   byte_t ctrl_q;
   logic  ctrl_we, ext_sel;
   logic [NPORTS-1:0] port_we;
   byte_t port_rd [NPORTS];
   byte_t rd_mux;

   mpx_bus_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_bus (
      .clk(clk), .rst_n(rst_n),
      .ale_i(ale_i), .cs_n_i(cs_n_i), .rd_n_i(rd_n_i), .wr_n_i(wr_n_i),
      .ad_i(ad_i), .addr_o(addr), .we_o(we), .wdata_o(wdata), .rd_en_o(rd_en)
   );

   assign ext_sel = (addr < BASE_ADDR);
   assign ctrl_we = we & (addr == CTRL_ADDR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctrl_q <= '0;
      else if (ctrl_we) ctrl_q <= wdata;
   end

   for (genvar k = 0; k < NPORTS; k++) begin : g_port
      assign port_we[k] = we & (addr == byte_t'(PORT_BASE + k));
      mpx_whole_port u_port (
         .clk(clk), .rst_n(rst_n),
         .we_i(port_we[k]), .wdata_i(wdata), .dir_out_i(ctrl_q[k]),
         .pin_in_i(port_in_i[8*k +: 8]),
         .pin_out_o(port_out_o[8*k +: 8]), .pin_oe_o(port_oe_o[8*k +: 8]),
         .rdata_o(port_rd[k])
      );
   end

   always_comb begin
      rd_mux = '0;
      if (ext_sel) rd_mux = ext_rdata_i;
      else if (addr == CTRL_ADDR) rd_mux = ctrl_q;
      for (int k = 0; k < NPORTS; k++) begin
         if (addr == byte_t'(PORT_BASE + k)) rd_mux = port_rd[k];
      end
   end

   assign ad_o        = rd_mux;
   assign ad_oe_o     = rd_en;
   assign ctrl_o      = ctrl_q[7:5];
   assign ext_wr_o    = we & ext_sel;
   assign ext_addr_o  = addr;
   assign ext_wdata_o = wdata;

   AST_WE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ext_wr_o, ctrl_we, port_we})) else $error("multiple write targets"); // R4
   AST_OE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_we |=> $stable(port_oe_o)) else $error("direction moved without write"); // R5
   AST_EXT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      ext_wr_o |=> !ext_wr_o) else $error("external write not a single pulse"); // R8
   if (SYNC_STAGES == 2) begin : g_rd_chk
      AST_RD_GATED: assert property (@(posedge clk) disable iff (!rst_n)
         ad_oe_o |-> (!$past(cs_n_i, 2) && !$past(rd_n_i, 2)))
         else $error("bus driven without select and read"); // R2
   end
endmodule

// File: tb/mbus_port_expander_tb.sv
module mbus_port_expander_tb;
   logic clk = 0;
   logic rst_n = 0;
   logic ale = 0, cs_n = 1, rd_n = 1, wr_n = 1;
   logic [7:0] ad = 0;
   logic [7:0] ad_o;
   logic ad_oe;
   logic [15:0] p_out, p_oe, p_in;
   logic [2:0] ctrl;
   logic ext_wr;
   logic [7:0] ext_addr, ext_wdata;
   logic [7:0] ext_rdata = 8'hC3;

   int checks = 0, failures = 0;
   int ext_count = 0;
   logic [7:0] ext_last_addr = 0, ext_last_data = 0;
   bit done = 0;

   logic [7:0] exp_q[$];
   string tag_q[$];
   event mon_ev;

   always #5 clk = ~clk;

   mbus_port_expander u_dut (
      .clk(clk), .rst_n(rst_n), .ale_i(ale), .cs_n_i(cs_n), .rd_n_i(rd_n), .wr_n_i(wr_n),
      .ad_i(ad), .ad_o(ad_o), .ad_oe_o(ad_oe),
      .port_out_o(p_out), .port_oe_o(p_oe), .port_in_i(p_in),
      .ctrl_o(ctrl), .ext_wr_o(ext_wr), .ext_addr_o(ext_addr), .ext_wdata_o(ext_wdata),
      .ext_rdata_i(ext_rdata)
   );

   task automatic check8(input logic [7:0] act, input logic [7:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: pops scoreboard on each read sample
   always @(mon_ev) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check8({7'd0, ad_oe}, 8'd1, {t, " (R3 drive)"});
      check8(ad_o, e, t);
   end

   always @(negedge clk) begin
      if (ext_wr) begin
         ext_count++;
         ext_last_addr = ext_addr;
         ext_last_data = ext_wdata;
      end
   end

   task automatic addr_phase(input logic [7:0] a, input bit sel);
      cs_n = !sel; ad = a; ale = 1;
      repeat (3) @(negedge clk);
      ale = 0;
      repeat (5) @(negedge clk);
   endtask

   task automatic data_write(input logic [7:0] d);
      ad = d; wr_n = 0;
      repeat (3) @(negedge clk);
      wr_n = 1;
      repeat (5) @(negedge clk);
      cs_n = 1;
      repeat (2) @(negedge clk);
   endtask

   task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
      addr_phase(a, 1);
      data_write(d);
   endtask

   task automatic bus_read(input logic [7:0] a, input logic [7:0] exp, input string tag);
      addr_phase(a, 1);
      rd_n = 0;
      repeat (4) @(negedge clk);
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      -> mon_ev;
      @(negedge clk);
      rd_n = 1; cs_n = 1;
      repeat (4) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      p_in = 16'h815A;
      repeat (3) @(negedge clk);
      // R9 reset state
      check8(p_oe[7:0], 8'h00, "R9 port B oe in reset");
      check8(p_oe[15:8], 8'h00, "R9 port C oe in reset");
      check8({5'd0, ctrl}, 8'h00, "R9 ctrl_o in reset");
      check8({7'd0, ad_oe}, 8'h00, "R9 bus idle in reset");
      rst_n = 1;
      repeat (2) @(negedge clk);
      bus_read(8'h03, 8'h5A, "R6 port B input reads pins");
      bus_read(8'h05, 8'h00, "R9 control cleared");
      check8({7'd0, ad_oe}, 8'h00, "R3 drive released after read");

      // R5/R7 direction and control
      bus_write(8'h05, 8'hA1);
      check8(p_oe[7:0], 8'hFF, "R5 port B all outputs");
      check8(p_oe[15:8], 8'h00, "R5 port C still inputs");
      check8({5'd0, ctrl}, 8'h05, "R7 ctrl_o bits");
      bus_read(8'h05, 8'hA1, "R7 control readback");

      // R4/R6 output data
      bus_write(8'h03, 8'h3C);
      check8(p_out[7:0], 8'h3C, "R4 port B data written");
      bus_read(8'h03, 8'h3C, "R6 port B output reads register");

      // port C: data written in input mode, then switched
      bus_write(8'h04, 8'h77);
      check8(p_oe[15:8], 8'h00, "R5 port C oe off in input mode");
      bus_read(8'h04, 8'h81, "R6 port C input reads pins");
      bus_write(8'h05, 8'h03);
      check8(p_oe[15:8], 8'hFF, "R5 port C switched to output");
      check8(p_out[15:8], 8'h77, "R5 port C drives held data");
      bus_read(8'h04, 8'h77, "R6 port C output reads register");
      check8({5'd0, ctrl}, 8'h00, "R7 ctrl_o follows rewrite");

      // R2 deselected cycle
      addr_phase(8'h03, 0);
      data_write(8'hFF);
      check8(p_out[7:0], 8'h3C, "R2 write ignored when deselected");
      cs_n = 1; rd_n = 0;
      repeat (4) @(negedge clk);
      check8({7'd0, ad_oe}, 8'h00, "R2 no drive when deselected");
      rd_n = 1;
      repeat (4) @(negedge clk);

      // R1 address held across later bus changes
      addr_phase(8'h03, 1);
      ad = 8'h04;
      repeat (4) @(negedge clk);
      data_write(8'h11);
      check8(p_out[7:0], 8'h11, "R1 latched address receives write");
      check8(p_out[15:8], 8'h77, "R1 decoy address untouched");

      // R8 external registers
      bus_read(8'h01, 8'hC3, "R8 external read data");
      bus_write(8'h02, 8'h9E);
      check8(ext_count[7:0], 8'd1, "R8 one external pulse");
      check8(ext_last_addr, 8'h02, "R8 external address");
      check8(ext_last_data, 8'h9E, "R8 external data");
      check8(p_out[7:0], 8'h11, "R8 port B unchanged by external write");
      bus_read(8'h05, 8'h03, "R8 control unchanged by external write");

      // R10 unmapped
      bus_write(8'h09, 8'hFF);
      check8(p_out[7:0], 8'h11, "R10 port B unchanged");
      check8(p_out[15:8], 8'h77, "R10 port C unchanged");
      check8(ext_count[7:0], 8'd1, "R10 no external pulse");
      bus_read(8'h05, 8'h03, "R10 control unchanged");
      bus_read(8'h09, 8'h00, "R10 unmapped reads zero");

      // R9 reset during operation
      rst_n = 0;
      @(negedge clk);
      check8(p_oe, 8'h00, "R9 oe cleared by reset");
      check8(p_out[7:0], 8'h00, "R9 port B data cleared");
      rst_n = 1;
      repeat (2) @(negedge clk);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule